// File: doc/BRIEF.md
# KCS Host Interface Controller

This block is the host-facing side of a keyboard-controller-style management interface. A host bus reaches it through a byte port with a single address bit. Offset 0 is the data register and offset 1 is the command/status register. The host writes control codes and data bytes, and it polls a status byte whose flags pace every transfer. The host checks the input-full flag before each write and the output-full flag before each read.

A four-state protocol engine collects a request message into a local buffer. When the final byte arrives, it hands the request to a management backend together with a length and a sequence tag, then holds the host off until the backend answers. The backend loads its response into a second buffer and strobes it in with the tag it was given. The controller then returns the response one byte at a time, each byte released by a read-byte code from the host. Aborts, illegal codes and oversized responses each produce a short error response, which the host drains through the same read path.

Top module: `kcs_host_ctrl`

## Requirements
- R1: A read at offset 1 returns the status byte, laid out as follows: bit 0 output-full, bit 1 input-full, bit 2 the level of `attn_in`, bit 3 set when the last accepted write went to offset 1, bits 7:6 the protocol state (0 idle, 1 read, 2 write, 3 error). A read at offset 0 returns the data-out byte. After reset the status is 0x00 with `attn_in` low, `req_valid` is low and `req_tag` is 0.
- R2: A host write while input-full is set is dropped and changes nothing. A host read at offset 0 clears output-full.
- R3: Command 0x60 in any state other than error does four things: it increments the pending tag, loads the one-byte response 0x01, enters the error state and sets output-full. In the error state, 0x60 changes nothing.
- R4: In idle, command 0x61 enters the write state, clears the request length and sets output-full.
- R5: In the write state each data byte is stored at the next request-buffer index and sets output-full. Bytes past DEPTH raise `req_len` (saturating at 2^LEN_W-1) but are not stored.
- R6: Command 0x62 in the write state sets output-full and marks the next data byte as the last one. After storing that byte, `req_valid` rises with `req_len` and `req_tag`, and all three hold until `req_ready`. Input-full stays set and output-full is not set while the controller waits for the response.
- R7: While waiting, a `rsp_valid` pulse is accepted only if `rsp_tag` equals `req_tag`; the tag then increments. A pulse with another tag is ignored. Backend writes to the response buffer take effect only while waiting.
- R8: When a response is accepted, the controller enters the read state, places response byte 0 in data-out, sets output-full and clears input-full. A zero-length response instead returns to idle with output-full set.
- R9: In the read state, once every response byte has been sent, any data byte returns the controller to idle with output-full set. Otherwise, data 0x68 moves the next response byte to data-out and sets output-full, and any other data byte loads error code 0x02, enters the error state and sets output-full.
- R10: In the error state, any data byte moves to the read state and places the first byte of the error response in data-out with output-full set.
- R11: A command that the current state does not consume loads error code 0x02 and enters the error state, leaving output-full unchanged.
- R12: A response with `rsp_len` greater than DEPTH keeps its first two bytes, followed by 0xCA, for a length of 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host byte write strobe |
| host_re | input | 1 | Host byte read strobe |
| host_addr | input | 1 | Register select: 0 data, 1 command/status |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational) |
| attn_in | input | 1 | Backend attention level shown in status |
| req_valid | output | 1 | Request ready for the backend |
| req_ready | input | 1 | Backend has taken the request |
| req_len | output | LEN_W | Request byte count |
| req_tag | output | TAG_W | Pending sequence tag |
| req_rd_idx | input | clog2(DEPTH) | Request buffer read index |
| req_rd_byte | output | 8 | Request byte at `req_rd_idx` |
| rsp_wr_en | input | 1 | Response buffer write strobe |
| rsp_wr_idx | input | clog2(DEPTH) | Response buffer write index |
| rsp_wr_byte | input | 8 | Response buffer write byte |
| rsp_valid | input | 1 | Response complete strobe |
| rsp_tag | input | TAG_W | Tag the response answers |
| rsp_len | input | LEN_W | Response byte count |

## Verification
The transfer path is tried with a short three-byte request and three-byte response. This shows that bytes come out in order and that the read state returns to idle exactly after the last byte. A request of 70 bytes separates counting from storing at the buffer edge: the length must reach 70 while index 0 keeps its first value. A response longer than DEPTH and a zero-length response separate the truncation path from the immediate-idle path. The error paths (illegal code in idle, abort in idle and again in error, a wrong byte mid-read) and a response with a stale tag tell recovery apart from silent acceptance.

// File: rtl/kcs_pkg.sv
package kcs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2,
      ST_ERROR = 2'd3
   } kcs_state_e;

   localparam logic [7:0] OP_ABORT    = 8'h60;
   localparam logic [7:0] OP_WR_START = 8'h61;
   localparam logic [7:0] OP_WR_END   = 8'h62;
   localparam logic [7:0] OP_RD_NEXT  = 8'h68;

   localparam logic [7:0] CODE_ABORTED = 8'h01;
   localparam logic [7:0] CODE_BAD_OP  = 8'h02;
   localparam logic [7:0] CC_TOO_LONG  = 8'hCA;
endpackage

// File: rtl/kcs_msg_buf.sv
module kcs_msg_buf #(
   parameter int DEPTH = 64,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign rdata = mem[raddr];
      end else begin : g_guarded
         assign rdata = (32'(raddr) < DEPTH) ? mem[raddr] : 8'h00;
      end
   endgenerate
endmodule

// File: rtl/kcs_host_ctrl.sv
module kcs_host_ctrl
   import kcs_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int LEN_W = 8,
   parameter int TAG_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       host_we,
   input  logic                       host_re,
   input  logic                       host_addr,
   input  logic [7:0]                 host_wdata,
   output logic [7:0]                 host_rdata,
   input  logic                       attn_in,
   output logic                       req_valid,
   input  logic                       req_ready,
   output logic [LEN_W-1:0]           req_len,
   output logic [TAG_W-1:0]           req_tag,
   input  logic [$clog2(DEPTH)-1:0]   req_rd_idx,
   output logic [7:0]                 req_rd_byte,
   input  logic                       rsp_wr_en,
   input  logic [$clog2(DEPTH)-1:0]   rsp_wr_idx,
   input  logic [7:0]                 rsp_wr_byte,
   input  logic                       rsp_valid,
   input  logic [TAG_W-1:0]           rsp_tag,
   input  logic [LEN_W-1:0]           rsp_len
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(DEPTH);
   localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
   localparam logic [TAG_W-1:0] TAG_ONE = TAG_W'(1);

   generate
      if (DEPTH < 4) begin : g_chk_depth
         $error("kcs_host_ctrl: DEPTH must be at least 4");
      end
      if (DEPTH >= (1 << LEN_W)) begin : g_chk_len
         $error("kcs_host_ctrl: LEN_W too narrow for DEPTH");
      end
      if (TAG_W < 1) begin : g_chk_tag
         $error("kcs_host_ctrl: TAG_W must be positive");
      end
   endgenerate

   kcs_state_e       st_q, st_n;
   logic             obf_q, obf_n, cd_q, cd_n, last_q, last_n;
   logic             busy_q, busy_n, reqv_q, reqv_n;
   logic [LEN_W-1:0] inlen_q, inlen_n, outlen_q, outlen_n, outpos_q, outpos_n;
   logic [7:0]       dout_q, dout_n;
   logic [TAG_W-1:0] tag_q, tag_n;

   logic             rq_we;
   logic             ri_we, err_load;
   logic [AW-1:0]    ri_idx;
   logic [7:0]       ri_d, err_code;
   logic             rs_we;
   logic [AW-1:0]    rs_widx, rs_ridx;
   logic [7:0]       rs_wd, rs_rdata;
   logic             accept, wr_ok;
   logic [LEN_W-1:0] eff_len;

   assign accept  = busy_q && rsp_valid && (rsp_tag == tag_q);
   assign wr_ok   = host_we && !busy_q;
   assign eff_len = (rsp_len > DEPTH_L) ? LEN_W'(3) : rsp_len;
   assign rs_ridx = busy_q ? '0 : outpos_q[AW-1:0];

   kcs_msg_buf #(.DEPTH(DEPTH)) u_req_buf (
      .clk(clk), .we(rq_we), .waddr(inlen_q[AW-1:0]), .wdata(host_wdata),
      .raddr(req_rd_idx), .rdata(req_rd_byte)
   );

   assign rs_we   = ri_we || (rsp_wr_en && busy_q);
   assign rs_widx = ri_we ? ri_idx : rsp_wr_idx;
   assign rs_wd   = ri_we ? ri_d : rsp_wr_byte;

   kcs_msg_buf #(.DEPTH(DEPTH)) u_rsp_buf (
      .clk(clk), .we(rs_we), .waddr(rs_widx), .wdata(rs_wd),
      .raddr(rs_ridx), .rdata(rs_rdata)
   );

   always_comb begin
      st_n     = st_q;     obf_n    = obf_q;    cd_n    = cd_q;
      last_n   = last_q;   busy_n   = busy_q;   reqv_n  = reqv_q;
      inlen_n  = inlen_q;  outlen_n = outlen_q; outpos_n = outpos_q;
      dout_n   = dout_q;   tag_n    = tag_q;
      rq_we    = 1'b0;     ri_we    = 1'b0;     ri_idx  = '0;  ri_d = 8'h00;
      err_load = 1'b0;     err_code = CODE_BAD_OP;

      if (reqv_q && req_ready) reqv_n = 1'b0;
      if (host_re && !host_addr) obf_n = 1'b0;

      if (accept) begin
         tag_n    = tag_q + TAG_ONE;
         busy_n   = 1'b0;
         reqv_n   = 1'b0;
         outlen_n = eff_len;
         obf_n    = 1'b1;
         if (rsp_len > DEPTH_L) begin
            ri_we  = 1'b1;
            ri_idx = AW'(2);
            ri_d   = CC_TOO_LONG;
         end
         if (eff_len == '0) begin
            st_n     = ST_IDLE;
            outpos_n = '0;
         end else begin
            st_n     = ST_READ;
            dout_n   = rs_rdata;
            outpos_n = LEN_ONE;
         end
      end else if (wr_ok) begin
         cd_n = host_addr;
         if (host_addr && host_wdata == OP_ABORT) begin
            if (st_q != ST_ERROR) begin
               tag_n    = tag_q + TAG_ONE;
               err_load = 1'b1;
               err_code = CODE_ABORTED;
               obf_n    = 1'b1;
            end
         end else begin
            unique case (st_q)
               ST_IDLE: begin
                  if (host_addr) begin
                     if (host_wdata == OP_WR_START) begin
                        st_n    = ST_WRITE;
                        inlen_n = '0;
                        last_n  = 1'b0;
                        obf_n   = 1'b1;
                     end else begin
                        err_load = 1'b1;
                     end
                  end
               end
               ST_WRITE: begin
                  if (host_addr) begin
                     if (host_wdata == OP_WR_END) begin
                        last_n = 1'b1;
                        obf_n  = 1'b1;
                     end else begin
                        err_load = 1'b1;
                     end
                  end else begin
                     rq_we = (inlen_q < DEPTH_L);
                     if (inlen_q != '1) inlen_n = inlen_q + LEN_ONE;
                     if (last_q) begin
                        last_n   = 1'b0;
                        busy_n   = 1'b1;
                        reqv_n   = 1'b1;
                        outpos_n = '0;
                     end else begin
                        obf_n = 1'b1;
                     end
                  end
               end
               ST_READ, ST_ERROR: begin
                  if (host_addr) begin
                     err_load = 1'b1;
                  end else if (outpos_q >= outlen_q) begin
                     st_n  = ST_IDLE;
                     obf_n = 1'b1;
                  end else if (st_q == ST_ERROR || host_wdata == OP_RD_NEXT) begin
                     st_n     = ST_READ;
                     dout_n   = rs_rdata;
                     outpos_n = outpos_q + LEN_ONE;
                     obf_n    = 1'b1;
                  end else begin
                     err_load = 1'b1;
                     obf_n    = 1'b1;
                  end
               end
               default: st_n = ST_IDLE;
            endcase
         end
         if (err_load) begin
            ri_we    = 1'b1;
            ri_idx   = '0;
            ri_d     = err_code;
            outlen_n = LEN_ONE;
            outpos_n = '0;
            st_n     = ST_ERROR;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;  obf_q <= 1'b0;  cd_q <= 1'b0;  last_q <= 1'b0;
         busy_q <= 1'b0;   reqv_q <= 1'b0; inlen_q <= '0; outlen_q <= '0;
         outpos_q <= '0;   dout_q <= 8'h00; tag_q <= '0;
      end else begin
         st_q <= st_n;     obf_q <= obf_n;   cd_q <= cd_n;   last_q <= last_n;
         busy_q <= busy_n; reqv_q <= reqv_n; inlen_q <= inlen_n; outlen_q <= outlen_n;
         outpos_q <= outpos_n; dout_q <= dout_n; tag_q <= tag_n;
      end
   end

   assign host_rdata = host_addr ? {st_q, 2'b00, cd_q, attn_in, busy_q, obf_q} : dout_q;
   assign req_valid  = reqv_q;
   assign req_len    = inlen_q;
   assign req_tag    = tag_q;
endmodule

// File: rtl/kcs_host_ctrl_chk.sv
module kcs_host_ctrl_chk #(
   parameter int LEN_W = 8,
   parameter int TAG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_we,
   input logic             host_re,
   input logic             host_addr,
   input logic [7:0]       host_wdata,
   input logic             req_valid,
   input logic             req_ready,
   input logic [LEN_W-1:0] req_len,
   input logic [TAG_W-1:0] req_tag,
   input logic             rsp_valid,
   input logic [TAG_W-1:0] rsp_tag,
   input logic [1:0]       st,
   input logic             busy,
   input logic             obf
);
   logic hit;
   assign hit = busy && rsp_valid && (rsp_tag == req_tag);

   // R2: writes during input-full leave the protocol state alone
   assert_drop_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy && host_we && !hit |=> $stable(st) && $stable(req_tag) && busy);

   // R2: a data read with nothing setting the flag clears output-full
   assert_read_clears_obf_R2: assert property (@(posedge clk) disable iff (!rst_n)
      host_re && !host_addr && !host_we && !hit |=> !obf);

   // R3: abort outside error
   assert_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
      host_we && !busy && host_addr && host_wdata == 8'h60 && st != 2'd3
      |=> st == 2'd3 && obf && req_tag == $past(req_tag) + TAG_W'(1));

   // R6: request held until taken
   assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready && !hit |=> req_valid && $stable(req_len) && $stable(req_tag));

   // R6: request only offered while waiting
   assert_req_in_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> busy);

   // R7: a stale tag is ignored
   assert_stale_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy && rsp_valid && rsp_tag != req_tag |=> busy && $stable(req_tag));

   // R8: accepted response releases the host
   assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !busy && obf && req_tag == $past(req_tag) + TAG_W'(1));
endmodule

bind kcs_host_ctrl kcs_host_ctrl_chk #(.LEN_W(LEN_W), .TAG_W(TAG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
   .host_addr(host_addr), .host_wdata(host_wdata), .req_valid(req_valid),
   .req_ready(req_ready), .req_len(req_len), .req_tag(req_tag),
   .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .st(st_q), .busy(busy_q), .obf(obf_q)
);

// File: tb/kcs_host_ctrl_bench.sv
module kcs_host_ctrl_bench;
   localparam int DEPTH = 64;
   localparam int AW    = $clog2(DEPTH);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_we = 1'b0, host_re = 1'b0, host_addr = 1'b0;
   logic [7:0] host_wdata = 8'h00, host_rdata;
   logic attn_in = 1'b0;
   logic req_valid, req_ready = 1'b0;
   logic [7:0] req_len, req_tag;
   logic [AW-1:0] req_rd_idx = '0;
   logic [7:0] req_rd_byte;
   logic rsp_wr_en = 1'b0;
   logic [AW-1:0] rsp_wr_idx = '0;
   logic [7:0] rsp_wr_byte = 8'h00;
   logic rsp_valid = 1'b0;
   logic [7:0] rsp_tag = 8'h00, rsp_len = 8'h00;

   int n_checks = 0;
   int n_err = 0;
   logic [7:0] exp_q[$];
   string      req_q[$];

   always #2 clk = ~clk;

   kcs_host_ctrl u_kcs_host_ctrl (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .attn_in(attn_in), .req_valid(req_valid), .req_ready(req_ready),
      .req_len(req_len), .req_tag(req_tag), .req_rd_idx(req_rd_idx),
      .req_rd_byte(req_rd_byte), .rsp_wr_en(rsp_wr_en), .rsp_wr_idx(rsp_wr_idx),
      .rsp_wr_byte(rsp_wr_byte), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
      .rsp_len(rsp_len)
   );

   // monitor: pops the expected byte for every host read
   always begin
      @(negedge clk);
      #1;
      if (host_re) begin
         n_checks++;
         if (exp_q.size() == 0) begin
            n_err++;
            $display("FAIL unexpected read: actual %02h expected none", host_rdata);
         end else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string r = req_q.pop_front();
            if (host_rdata !== e) begin
               n_err++;
               $display("FAIL %s: host read actual %02h expected %02h", r, host_rdata, e);
            end
         end
      end
   end

   task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", r, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic rd(input logic a, input logic [7:0] e, input string r);
      @(negedge clk);
      host_re = 1'b1; host_addr = a;
      exp_q.push_back(e);
      req_q.push_back(r);
      @(negedge clk);
      host_re = 1'b0;
   endtask

   task automatic be_write(input int idx, input logic [7:0] d);
      @(negedge clk);
      rsp_wr_en = 1'b1; rsp_wr_idx = AW'(idx); rsp_wr_byte = d;
      @(negedge clk);
      rsp_wr_en = 1'b0;
   endtask

   task automatic be_respond(input logic [7:0] t, input logic [7:0] l);
      @(negedge clk);
      rsp_valid = 1'b1; rsp_tag = t; rsp_len = l;
      @(negedge clk);
      rsp_valid = 1'b0;
   endtask

   task automatic be_take();
      @(negedge clk);
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(1, 8'h00, "R1 reset status");
      chk("R1 reset req_valid", 16'(req_valid), 16'h0);
      chk("R1 reset req_tag", 16'(req_tag), 16'h0);
      @(negedge clk); attn_in = 1'b1;
      rd(1, 8'h04, "R1 attention bit");
      @(negedge clk); attn_in = 1'b0;

      // R11 illegal command in idle, R10 drain it
      wr(1, 8'h62);
      rd(1, 8'hC8, "R11 illegal command");
      wr(0, 8'h00);
      rd(1, 8'h41, "R10 error to read");
      rd(0, 8'h02, "R10 error code");
      rd(1, 8'h40, "R2 data read clears OBF");
      wr(0, 8'h68);
      rd(1, 8'h01, "R9 end of response to idle");
      rd(0, 8'h02, "R9 data unchanged");

      // R3 abort in idle then in error
      wr(1, 8'h60);
      rd(1, 8'hC9, "R3 abort status");
      chk("R3 abort tag", 16'(req_tag), 16'h1);
      wr(1, 8'h60);
      chk("R3 abort in error keeps tag", 16'(req_tag), 16'h1);
      wr(0, 8'h68);
      rd(0, 8'h01, "R3 aborted code");
      wr(0, 8'h68);
      rd(1, 8'h01, "R9 idle after abort drain");
      rd(0, 8'h01, "R9 data unchanged");

      // R4 R5 R6 three-byte request
      wr(1, 8'h61);
      rd(1, 8'h89, "R4 write start");
      rd(0, 8'h01, "R4 clear OBF");
      wr(0, 8'h11);
      rd(1, 8'h81, "R5 data byte sets OBF");
      wr(0, 8'h22);
      wr(1, 8'h62);
      rd(1, 8'h89, "R6 write end");
      rd(0, 8'h01, "R6 clear OBF");
      wr(0, 8'h33);
      rd(1, 8'h82, "R6 waiting status");
      chk("R6 req_valid", 16'(req_valid), 16'h1);
      chk("R6 req_len", 16'(req_len), 16'h3);
      chk("R6 req_tag", 16'(req_tag), 16'h1);
      for (int i = 0; i < 3; i++) begin
         req_rd_idx = AW'(i); #1;
         chk("R5 request byte", 16'(req_rd_byte), 16'(8'h11 * (i + 1)));
      end
      wr(1, 8'h60);
      rd(1, 8'h82, "R2 write dropped while input-full");
      chk("R2 tag unchanged by dropped abort", 16'(req_tag), 16'h1);
      repeat (3) @(negedge clk);
      chk("R6 req_valid held", 16'(req_valid), 16'h1);
      be_take();
      chk("R6 req_valid dropped after ready", 16'(req_valid), 16'h0);

      // R7 R8 R9 response
      be_write(0, 8'hA0); be_write(1, 8'hA1); be_write(2, 8'hA2);
      be_respond(8'h00, 8'd3);
      rd(1, 8'h82, "R7 stale tag ignored");
      be_respond(8'h01, 8'd3);
      chk("R7 tag increments", 16'(req_tag), 16'h2);
      rd(1, 8'h41, "R8 read state after accept");
      be_write(1, 8'hEE);
      rd(0, 8'hA0, "R8 first byte");
      wr(0, 8'h68);
      rd(0, 8'hA1, "R7 backend write ignored when not waiting");
      wr(0, 8'h68);
      rd(0, 8'hA2, "R9 third byte");
      wr(0, 8'h68);
      rd(1, 8'h01, "R9 idle after last byte");
      rd(0, 8'hA2, "R9 data unchanged");

      // R12 oversized response
      wr(1, 8'h61);
      wr(1, 8'h62);
      rd(0, 8'hA2, "R12 clear OBF");
      wr(0, 8'h55);
      chk("R6 single-byte req_len", 16'(req_len), 16'h1);
      chk("R6 single-byte req_tag", 16'(req_tag), 16'h2);
      be_take();
      be_write(0, 8'hB0); be_write(1, 8'hB1); be_write(2, 8'hB2);
      be_respond(8'h02, 8'(DEPTH + 1));
      rd(0, 8'hB0, "R12 byte 0 kept");
      wr(0, 8'h68);
      rd(0, 8'hB1, "R12 byte 1 kept");
      wr(0, 8'h68);
      rd(0, 8'hCA, "R12 completion code");
      wr(0, 8'h68);
      rd(1, 8'h01, "R12 length 3 then idle");
      rd(0, 8'hCA, "R12 data unchanged");

      // R5 overflow, R9 bad byte, R10
      wr(1, 8'h61);
      for (int i = 0; i < 69; i++) wr(0, 8'(i));
      wr(1, 8'h62);
      wr(0, 8'd69);
      chk("R5 length counts past depth", 16'(req_len), 16'd70);
      req_rd_idx = '0; #1;
      chk("R5 index 0 not overwritten", 16'(req_rd_byte), 16'h0);
      req_rd_idx = AW'(DEPTH - 1); #1;
      chk("R5 last stored byte", 16'(req_rd_byte), 16'(DEPTH - 1));
      be_take();
      be_write(0, 8'hC0); be_write(1, 8'hC1);
      be_respond(8'h03, 8'd2);
      rd(0, 8'hC0, "R8 first byte");
      wr(0, 8'h12);
      rd(1, 8'hC1, "R9 bad byte gives error");
      rd(0, 8'hC0, "R9 data unchanged");
      wr(0, 8'h68);
      rd(0, 8'h02, "R10 error code after bad byte");
      wr(0, 8'h68);
      rd(1, 8'h01, "R9 idle after error drain");

      // R8 zero-length response
      wr(1, 8'h61);
      wr(1, 8'h62);
      rd(0, 8'h02, "R8 clear OBF");
      wr(0, 8'h77);
      be_take();
      be_respond(8'h04, 8'd0);
      rd(1, 8'h01, "R8 empty response to idle");
      chk("R8 tag after empty response", 16'(req_tag), 16'h5);

      @(negedge clk);
      #2;
      finish_run();
   end
endmodule